// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits in a converter's output data path, between the 14-bit sample source and the framing logic that follows it. On every clock it emits one word, taken either from the live ADC sample or from a known pattern selected by a 4-bit mode field. Engineers use it while bringing up a serial link, so that the receiver can check alignment, bit ordering and lane mapping against words it can predict.

The sources are: the live sample, constant zeros, constant ones, an alternating bit toggle, a rising ramp, one programmable word, two programmable words in alternation, a fixed deskew word and a fixed sync word. Every output is registered, so each word appears one clock after the inputs that choose it. The sequenced patterns (toggle, ramp, two-word alternation) start over from their first element after reset and whenever the mode field changes.

Top module: `tpg_top`

## Requirements
- R1: While `rst` is high, `word_o` is 0 and `valid_o` is 0. Each output word reflects the inputs sampled at the previous rising edge, and `valid_o` is 1 from the first edge with `rst` low.
- R2: Mode 4'b0000 passes `sample_i` through unchanged. The unlisted codes 4'b0101 and 4'b1010 through 4'b1111 act the same way.
- R3: Mode 4'b0001 outputs 14'h0000, and mode 4'b0010 outputs 14'h3FFF.
- R4: Mode 4'b0011 alternates every clock, starting with 14'h2AAA (bits 13,11,...,1 set) and then 14'h1555.
- R5: Mode 4'b0100 outputs a ramp that starts at 0, rises by one per clock, and wraps from 14'h3FFF to 14'h0000.
- R6: Mode 4'b0110 outputs the value of `cust_a_i` sampled at each edge.
- R7: Mode 4'b0111 alternates on each clock between `cust_a_i` and `cust_b_i`, starting with `cust_a_i`.
- R8: Mode 4'b1000 outputs 14'h2AAA, and mode 4'b1001 outputs 14'h3FFF.
- R9: After reset, and on the first edge at which `mode_i` differs from its value at the previous edge, the toggle, ramp and two-word sequences start again from their first element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 14 | Live ADC sample |
| mode_i | input | 4 | Pattern source select |
| cust_a_i | input | 14 | First programmable pattern word |
| cust_b_i | input | 14 | Second programmable pattern word |
| word_o | output | 14 | Registered output word |
| valid_o | output | 1 | Output word is meaningful |

## Verification
The hardest case to reach from the ports is the ramp wrap. It only shows up after 16384 clocks without a mode change, so a directed run holds the ramp mode through a full cycle and checks the step from 3FFF back to 0000. The restart rule is the other subtle case. Random stimulus changes the mode at random intervals, often for only one or two clocks and sometimes straight back to the previous mode, so that sequences are cut off midway and must begin again at their first element.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [3:0] {
    SRC_LIVE   = 4'b0000,
    SRC_ZERO   = 4'b0001,
    SRC_ONES   = 4'b0010,
    SRC_TOGGLE = 4'b0011,
    SRC_RAMP   = 4'b0100,
    SRC_CUST1  = 4'b0110,
    SRC_CUST12 = 4'b0111,
    SRC_DESKEW = 4'b1000,
    SRC_SYNC   = 4'b1001
  } src_e;

  // Collapse unlisted codes onto live data.
  function automatic src_e decode_src(input logic [3:0] code);
    case (code)
      4'b0001: decode_src = SRC_ZERO;
      4'b0010: decode_src = SRC_ONES;
      4'b0011: decode_src = SRC_TOGGLE;
      4'b0100: decode_src = SRC_RAMP;
      4'b0110: decode_src = SRC_CUST1;
      4'b0111: decode_src = SRC_CUST12;
      4'b1000: decode_src = SRC_DESKEW;
      4'b1001: decode_src = SRC_SYNC;
      default: decode_src = SRC_LIVE;
    endcase
  endfunction
endpackage

// File: rtl/tpg_seq.sv
// Sequence state: phase bit for two-element patterns and ramp counter.
// Both restart when the mode changes or after reset.
module tpg_seq #(
  parameter int W = 14,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] mode_i,
  output logic          phase_o,
  output logic [W-1:0]  ramp_o
);
  logic [MW-1:0] mode_q;
  logic          phase_q;
  logic [W-1:0]  ramp_q;
  logic          fresh;

  assign fresh   = (mode_i != mode_q);
  assign phase_o = fresh ? 1'b0 : phase_q;
  assign ramp_o  = fresh ? '0 : ramp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      phase_q <= 1'b0;
      ramp_q  <= '0;
    end else begin
      mode_q  <= mode_i;
      phase_q <= ~phase_o;
      ramp_q  <= ramp_o + 1'b1;
    end
  end

  // A change of mode must restart the counter on the next cycle.
  AST_RESTART_RAMP: assert property (@(posedge clk) disable iff (rst)
    (mode_i != $past(mode_i)) |=> (ramp_q == W'(1))) else $error("restart");  // R9
endmodule

// File: rtl/tpg_select.sv
// Combinational choice of the next output word.
module tpg_select #(
  parameter int W = 14
) (
  input  tpg_pkg::src_e src_i,
  input  logic [W-1:0]  sample_i,
  input  logic [W-1:0]  cust_a_i,
  input  logic [W-1:0]  cust_b_i,
  input  logic          phase_i,
  input  logic [W-1:0]  ramp_i,
  output logic [W-1:0]  word_o
);
  import tpg_pkg::*;

  logic [W-1:0] alt_hi;  // MSB set, alternate bits below

  for (genvar b = 0; b < W; b++) begin : g_alt
    assign alt_hi[b] = ((W - 1 - b) % 2 == 0);
  end

  always_comb begin
    case (src_i)
      SRC_ZERO:   word_o = '0;
      SRC_ONES:   word_o = '1;
      SRC_TOGGLE: word_o = phase_i ? ~alt_hi : alt_hi;
      SRC_RAMP:   word_o = ramp_i;
      SRC_CUST1:  word_o = cust_a_i;
      SRC_CUST12: word_o = phase_i ? cust_b_i : cust_a_i;
      SRC_DESKEW: word_o = alt_hi;
      SRC_SYNC:   word_o = '1;
      default:    word_o = sample_i;
    endcase
  end
endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
  parameter int W = 14,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  sample_i,
  input  logic [MW-1:0] mode_i,
  input  logic [W-1:0]  cust_a_i,
  input  logic [W-1:0]  cust_b_i,
  output logic [W-1:0]  word_o,
  output logic          valid_o
);
  import tpg_pkg::*;

  localparam logic [W-1:0] ALT_WORD = W'(14'h2AAA);

  src_e         src;
  logic         phase;
  logic [W-1:0] ramp;
  logic [W-1:0] next_word;

  assign src = decode_src(mode_i);

  tpg_seq #(.W(W), .MW(MW)) u_seq (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .phase_o(phase), .ramp_o(ramp)
  );

  tpg_select #(.W(W)) u_sel (
    .src_i(src), .sample_i(sample_i), .cust_a_i(cust_a_i),
    .cust_b_i(cust_b_i), .phase_i(phase), .ramp_i(ramp),
    .word_o(next_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      word_o  <= next_word;
      valid_o <= 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!valid_o && word_o == '0)) else $error("reset");  // R1
  AST_LIVE_PASS: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 4'b0000) |=> (word_o == $past(sample_i))) else $error("live");  // R2
  AST_DESKEW_WORD: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 4'b1000) |=> (word_o == ALT_WORD)) else $error("deskew");  // R8
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && mode_i == 4'b0011 && $past(mode_i) == 4'b0011)
    |=> (word_o == ~$past(word_o))) else $error("toggle");  // R4
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && mode_i == 4'b0100 && $past(mode_i) == 4'b0100)
    |=> (word_o == W'($past(word_o) + 1'b1))) else $error("ramp");  // R5
endmodule

// File: tb/test_tpg_top.sv
module test_tpg_top;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] sample_i = '0;
  logic [3:0]   mode_i = '0;
  logic [W-1:0] cust_a_i = '0;
  logic [W-1:0] cust_b_i = '0;
  logic [W-1:0] word_o;
  logic         valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench model state
  logic [3:0]   m_mode = '0;
  logic         m_phase = 1'b0;
  logic [W-1:0] m_ramp = '0;
  logic [W-1:0] exp_word = '0;
  logic         exp_valid = 1'b0;
  string        exp_tag = "R1";

  always #4 clk = ~clk;

  tpg_top #(.W(W), .MW(4)) i_tpg_top (
    .clk(clk), .rst(rst), .sample_i(sample_i), .mode_i(mode_i),
    .cust_a_i(cust_a_i), .cust_b_i(cust_b_i),
    .word_o(word_o), .valid_o(valid_o)
  );

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'b0001, 4'b0010: return "R3";
      4'b0011: return "R4";
      4'b0100: return "R5";
      4'b0110: return "R6";
      4'b0111: return "R7";
      4'b1000, 4'b1001: return "R8";
      default: return "R2";
    endcase
  endfunction

  // Computes the word for current inputs and advances the model (R9 restart).
  task automatic model_step();
    logic fresh;
    logic ph;
    logic [W-1:0] rp;
    fresh = (mode_i != m_mode);
    ph = fresh ? 1'b0 : m_phase;
    rp = fresh ? '0 : m_ramp;
    case (mode_i)
      4'b0001: exp_word = 14'h0000;
      4'b0010: exp_word = 14'h3FFF;
      4'b0011: exp_word = ph ? 14'h1555 : 14'h2AAA;
      4'b0100: exp_word = rp;
      4'b0110: exp_word = cust_a_i;
      4'b0111: exp_word = ph ? cust_b_i : cust_a_i;
      4'b1000: exp_word = 14'h2AAA;
      4'b1001: exp_word = 14'h3FFF;
      default: exp_word = sample_i;
    endcase
    exp_valid = 1'b1;
    exp_tag = fresh ? {tag_of(mode_i), "/R9"} : tag_of(mode_i);
    m_mode = mode_i;
    m_phase = ~ph;
    m_ramp = rp + 1'b1;
  endtask

  task automatic check_out();
    n_cmp++;
    if (word_o !== exp_word || valid_o !== exp_valid) begin
      n_bad++;
      $display("FAIL %s: got word=%h valid=%b expected word=%h valid=%b",
               exp_tag, word_o, valid_o, exp_word, exp_valid);
    end
  endtask

  // One clock: check previous result, apply new inputs, predict.
  task automatic cycle(input logic [3:0] m, input logic [W-1:0] s,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    check_out();
    mode_i = m; sample_i = s; cust_a_i = a; cust_b_i = b;
    model_step();
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    check_out();
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      exp_word = '0; exp_valid = 1'b0; exp_tag = "R1";
      check_out();
    end
    m_mode = '0; m_phase = 1'b0; m_ramp = '0;
    rst = 1'b0;
    model_step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    // R1: reset state, with ramp mode held across reset
    mode_i = 4'b0100;
    repeat (2) @(negedge clk);
    exp_word = '0; exp_valid = 1'b0; exp_tag = "R1";
    check_out();
    rst = 1'b0;
    model_step();
    // R5: ramp from 0 through a full wrap
    for (int i = 0; i < 16390; i++) cycle(4'b0100, 14'h1234, 14'h0, 14'h0);
    // R4 toggle, R7 alternation, R6, R8, R3, R2 directed
    for (int i = 0; i < 5; i++) cycle(4'b0011, 14'h0, 14'h0, 14'h0);
    for (int i = 0; i < 5; i++) cycle(4'b0111, 14'h0, 14'h0F0F, 14'h30C3);
    cycle(4'b0110, 14'h0, 14'h1ABC, 14'h0);
    cycle(4'b0110, 14'h0, 14'h0DEF, 14'h0);
    cycle(4'b1000, 14'h3FFF, 14'h0, 14'h0);
    cycle(4'b1001, 14'h0, 14'h0, 14'h0);
    cycle(4'b0001, 14'h3FFF, 14'h0, 14'h0);
    cycle(4'b0010, 14'h0, 14'h0, 14'h0);
    cycle(4'b0000, 14'h2468, 14'h0, 14'h0);
    // R2 unlisted codes
    for (int c = 10; c < 16; c++) cycle(4'(c), 14'(c * 777), 14'h0, 14'h0);
    cycle(4'b0101, 14'h1357, 14'h0, 14'h0);
    // R9: reset mid-sequence, toggle restarts
    cycle(4'b0011, 14'h0, 14'h0, 14'h0);
    cycle(4'b0011, 14'h0, 14'h0, 14'h0);
    do_reset(2);
    cycle(4'b0011, 14'h0, 14'h0, 14'h0);
    // Random: short mode runs, returning to recent modes
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] m;
      m = ($urandom % 3 == 0) ? 4'($urandom) : mode_i;
      if ($urandom % 200 == 0) do_reset(1);
      cycle(m, 14'($urandom), 14'($urandom), 14'($urandom));
    end
    @(negedge clk);
    check_out();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule